// File: doc/BRIEF.md
# Keyed write-protection and security-lock controller

This block supervises the security state of a cryptographic engine. A single mode register holds three protection enables, one each for the configuration, interrupt and control register groups. The same register holds a three-bit reaction policy and a bit that selects first-error or last-error capture. The protection enables change only when the write carries a 24-bit password in its upper bits. The policy and capture fields can be written freely.

Five abnormal-event inputs set sticky flags:
- key-bus violation
- write-protection violation
- clock/glitch detect
- sequence error
- software error

The block records the source of a write-protection violation and the type of a software error. It pulses a security-error interrupt on the first error of a series. Reading the status ends the current series.

Based on the policy, a qualifying event locks the engine, so that no new operation may start. Under some policies the event also pulses a key-wipe output. An operation already running is not stopped by the lock. The lock is released only by an unlock command issued after every flag that could cause it has been cleared. The sequence-error flag is cleared only by a status read followed by a software reset.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After reset, all of the following are zero: `rd_data`, the protection enables, `flags_o`, `lock_o`, `key_clr_o`, `sec_irq_o`, `src_o` and `typ_o`.
- R2: A mode write updates the enables only when `wr_data[31:8]` equals 0x414553. The enables are bit 0 (configuration), bit 1 (interrupt) and bit 2 (control). With any other key value the enables keep their value.
- R3: A mode write always stores `wr_data[7:5]` as the action code and `wr_data[4]` as the first-error bit. On readback, bits 31:8 and bit 3 are zero and bits 7:0 show the stored fields. All mode effects are visible one cycle after the write.
- R4: Event bit k sets `flags_o[k]` one cycle later. The event bits are:
  - bit 0: key-bus violation
  - bit 1: write-protection violation
  - bit 2: glitch
  - bit 3: sequence error
  - bit 4: software error

  A status read (`sts_rd_i`) clears flags 0, 1, 2 and 4. An event arriving in the same cycle as the read wins.
- R5: Each action code locks on a group of events:
  - codes 1 and 4: events {0,1,4}
  - codes 2 and 5: events {2,3}
  - codes 3 and 6: all five events
  - codes 0 and 7: no event

  `lock_o` rises one cycle after an event in the group.
- R6: Under codes 4, 5 and 6, an event in the group raises `key_clr_o` for exactly the next cycle, unless another such event follows.
- R7: `start_o` equals `start_req_i` while `lock_o` is low, and is low while `lock_o` is high.
- R8: `unlock_i` clears `lock_o` on the next cycle only when no flag in the current group is set and no event in the group arrives in that cycle. Otherwise the lock stays.
- R9: Flag 3 is not cleared by a status read alone, nor by a software reset alone. A status read made while flag 3 is set, followed by a later `swrst_i`, clears it. A new sequence error cancels a pending read.
- R10: For a write-protection violation, `src_i` is captured to `src_o`. For a software error, `typ_i` is captured to `typ_o`. With the first-error bit at 0, every such event overwrites the stored value. With the bit at 1, only the first event of that kind since the last status read is kept.
- R11: `sec_irq_o` pulses for one cycle after the first event of a series. A status read ends the series, and an event in the same cycle as the read starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 32 | Mode write data (key in 31:8) |
| rd_data | output | 32 | Mode register readback |
| prot_cfg_o | output | 1 | Configuration group protection enable |
| prot_int_o | output | 1 | Interrupt group protection enable |
| prot_ctl_o | output | 1 | Control group protection enable |
| evt_i | input | 5 | Abnormal event pulses |
| src_i | input | 8 | Violation source, qualified by evt_i[1] |
| typ_i | input | 4 | Software error type, qualified by evt_i[4] |
| sts_rd_i | input | 1 | Status read strobe |
| swrst_i | input | 1 | Software reset command |
| unlock_i | input | 1 | Unlock command |
| start_req_i | input | 1 | Request to start a new operation |
| start_o | output | 1 | Granted start |
| lock_o | output | 1 | Engine locked |
| key_clr_o | output | 1 | Key wipe pulse |
| sec_irq_o | output | 1 | Security error interrupt pulse |
| flags_o | output | 5 | Sticky event flags |
| src_o | output | 8 | Captured violation source |
| typ_o | output | 4 | Captured software error type |

## Verification
The checker watches several properties on every cycle:
- a key wipe is always accompanied by the lock;
- a start is never granted while locked;
- an interrupt pulse always coincides with a set flag;
- a wrong-key write leaves the enables unchanged;
- a raised event shows in its flag on the next cycle;
- a lock held by a pending sequence error is never released.

Some behaviours need a history of stimulus to show, and only the bench scenarios cover them:
- the event-group mapping of each action code;
- first-error versus last-error capture;
- the read-then-reset order for clearing the sequence error;
- the opening and closing of error series.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
   localparam int NUM_EVT = 5;
   localparam int EV_KEYBUS = 0;
   localparam int EV_WPROT  = 1;
   localparam int EV_GLITCH = 2;
   localparam int EV_SEQ    = 3;
   localparam int EV_SWERR  = 4;

   typedef enum logic [2:0] {
      ACT_REPORT   = 3'd0,
      ACT_LOCK_A   = 3'd1,
      ACT_LOCK_B   = 3'd2,
      ACT_LOCK_ALL = 3'd3,
      ACT_CLR_A    = 3'd4,
      ACT_CLR_B    = 3'd5,
      ACT_CLR_ALL  = 3'd6,
      ACT_RSVD     = 3'd7
   } act_e;

   localparam logic [NUM_EVT-1:0] GRP_A   = 5'b10011;
   localparam logic [NUM_EVT-1:0] GRP_B   = 5'b01100;
   localparam logic [NUM_EVT-1:0] GRP_ALL = 5'b11111;

   function automatic logic [NUM_EVT-1:0] group_mask(input act_e a);
      case (a)
         ACT_LOCK_A, ACT_CLR_A:     group_mask = GRP_A;
         ACT_LOCK_B, ACT_CLR_B:     group_mask = GRP_B;
         ACT_LOCK_ALL, ACT_CLR_ALL: group_mask = GRP_ALL;
         default:                   group_mask = '0;
      endcase
   endfunction

   function automatic logic wipes_key(input act_e a);
      wipes_key = (a == ACT_CLR_A) || (a == ACT_CLR_B) || (a == ACT_CLR_ALL);
   endfunction
endpackage

// File: rtl/wp_mode_reg.sv
module wp_mode_reg
   import wp_lock_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          KEY_W  = 24,
   parameter logic [23:0] PASSWD = 24'h414553
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [2:0]        prot_en,
   output act_e              action,
   output logic              first_mode,
   output logic [DATA_W-1:0] rd_data
);
   localparam int LOW_W = DATA_W - KEY_W;

   initial begin
      if (LOW_W != 8) $fatal(1, "wp_mode_reg: key must leave exactly 8 low bits");
      if (KEY_W != 24) $fatal(1, "wp_mode_reg: key width must be 24");
   end

   logic key_ok;
   assign key_ok = (wr_data[DATA_W-1:LOW_W] == PASSWD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_en    <= '0;
         action     <= ACT_REPORT;
         first_mode <= 1'b0;
      end else if (wr_en) begin
         action     <= act_e'(wr_data[7:5]);
         first_mode <= wr_data[4];
         if (key_ok) prot_en <= wr_data[2:0];
      end
   end

   always_comb begin
      rd_data      = '0;
      rd_data[2:0] = prot_en;
      rd_data[4]   = first_mode;
      rd_data[7:5] = action;
   end
endmodule

// File: rtl/wp_capture.sv
module wp_capture #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         sts_rd,
   input  logic         first_mode,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] data_q
);
   initial begin
      if (W < 1) $fatal(1, "wp_capture: width must be positive");
   end

   logic held;
   logic take;

   assign take = cap && (!first_mode || !held || sts_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= 1'b0;
         data_q <= '0;
      end else begin
         if (take) data_q <= data_i;
         if (cap) held <= 1'b1;
         else if (sts_rd) held <= 1'b0;
      end
   end
endmodule

// File: rtl/wp_event_log.sv
module wp_event_log
   import wp_lock_pkg::*;
#(
   parameter int SRC_W = 8,
   parameter int TYP_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic               sts_rd,
   input  logic               swrst,
   input  logic               first_mode,
   input  logic [SRC_W-1:0]   src_i,
   input  logic [TYP_W-1:0]   typ_i,
   output logic [NUM_EVT-1:0] flags,
   output logic [SRC_W-1:0]   src_q,
   output logic [TYP_W-1:0]   typ_q,
   output logic               sec_irq
);
   logic seq_armed;
   logic series_open;
   logic any_evt;

   assign any_evt = |evt;

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
      if (k == EV_SEQ) begin : g_seq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[k]  <= 1'b0;
               seq_armed <= 1'b0;
            end else begin
               if (evt[k]) flags[k] <= 1'b1;
               else if (swrst && seq_armed) flags[k] <= 1'b0;
               if (evt[k]) seq_armed <= 1'b0;
               else if (sts_rd && flags[k]) seq_armed <= 1'b1;
               else if (swrst) seq_armed <= 1'b0;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[k] <= 1'b0;
            else if (evt[k]) flags[k] <= 1'b1;
            else if (sts_rd) flags[k] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         series_open <= 1'b0;
         sec_irq     <= 1'b0;
      end else begin
         sec_irq <= any_evt && (!series_open || sts_rd);
         if (any_evt) series_open <= 1'b1;
         else if (sts_rd) series_open <= 1'b0;
      end
   end

   wp_capture #(.W(SRC_W)) u_cap_src (
      .clk(clk), .rst_n(rst_n), .cap(evt[EV_WPROT]), .sts_rd(sts_rd),
      .first_mode(first_mode), .data_i(src_i), .data_q(src_q)
   );

   wp_capture #(.W(TYP_W)) u_cap_typ (
      .clk(clk), .rst_n(rst_n), .cap(evt[EV_SWERR]), .sts_rd(sts_rd),
      .first_mode(first_mode), .data_i(typ_i), .data_q(typ_q)
   );
endmodule

// File: rtl/wp_lock_fsm.sv
module wp_lock_fsm
   import wp_lock_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [NUM_EVT-1:0] flags,
   input  act_e               action,
   input  logic               unlock,
   output logic               lock,
   output logic               key_clr
);
   logic [NUM_EVT-1:0] grp;
   logic               trig;
   logic               src_busy;

   assign grp      = group_mask(action);
   assign trig     = |(evt & grp);
   assign src_busy = |(flags & grp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock    <= 1'b0;
         key_clr <= 1'b0;
      end else begin
         key_clr <= trig && wipes_key(action);
         if (trig) lock <= 1'b1;
         else if (unlock && !src_busy) lock <= 1'b0;
      end
   end
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
   import wp_lock_pkg::*;
#(
   parameter int          DATA_W = 32,
   parameter int          KEY_W  = 24,
   parameter logic [23:0] PASSWD = 24'h414553,
   parameter int          SRC_W  = 8,
   parameter int          TYP_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               prot_cfg_o,
   output logic               prot_int_o,
   output logic               prot_ctl_o,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [SRC_W-1:0]   src_i,
   input  logic [TYP_W-1:0]   typ_i,
   input  logic               sts_rd_i,
   input  logic               swrst_i,
   input  logic               unlock_i,
   input  logic               start_req_i,
   output logic               start_o,
   output logic               lock_o,
   output logic               key_clr_o,
   output logic               sec_irq_o,
   output logic [NUM_EVT-1:0] flags_o,
   output logic [SRC_W-1:0]   src_o,
   output logic [TYP_W-1:0]   typ_o
);
   logic [2:0] prot_en;
   act_e       action;
   logic       first_mode;

   wp_mode_reg #(.DATA_W(DATA_W), .KEY_W(KEY_W), .PASSWD(PASSWD)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .prot_en(prot_en), .action(action), .first_mode(first_mode),
      .rd_data(rd_data)
   );

   wp_event_log #(.SRC_W(SRC_W), .TYP_W(TYP_W)) u_log (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .sts_rd(sts_rd_i),
      .swrst(swrst_i), .first_mode(first_mode), .src_i(src_i),
      .typ_i(typ_i), .flags(flags_o), .src_q(src_o), .typ_q(typ_o),
      .sec_irq(sec_irq_o)
   );

   wp_lock_fsm u_lock (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .flags(flags_o),
      .action(action), .unlock(unlock_i), .lock(lock_o),
      .key_clr(key_clr_o)
   );

   assign prot_cfg_o = prot_en[0];
   assign prot_int_o = prot_en[1];
   assign prot_ctl_o = prot_en[2];
   assign start_o    = start_req_i && !lock_o;
endmodule

// File: rtl/wp_lock_ctrl_chk.sv
module wp_lock_ctrl_chk #(
   parameter int          DATA_W = 32,
   parameter logic [23:0] PASSWD = 24'h414553
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              prot_cfg_o,
   input logic              prot_int_o,
   input logic              prot_ctl_o,
   input logic [4:0]        evt_i,
   input logic              start_o,
   input logic              lock_o,
   input logic              key_clr_o,
   input logic              sec_irq_o,
   input logic [4:0]        flags_o
);
   logic seq_locking_act;
   assign seq_locking_act = (rd_data[7:5] == 3'd2) || (rd_data[7:5] == 3'd3) ||
                            (rd_data[7:5] == 3'd5) || (rd_data[7:5] == 3'd6);

   p_wipe_with_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      key_clr_o |-> lock_o);

   p_no_start_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> !start_o);

   p_irq_has_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_irq_o |-> (flags_o != 5'd0));

   p_bad_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31:8] != PASSWD) |=>
         ($stable(prot_cfg_o) && $stable(prot_int_o) && $stable(prot_ctl_o)));

   p_evt_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != 5'd0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

   p_seq_holds_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && flags_o[3] && seq_locking_act) |=> lock_o);
endmodule

bind wp_lock_ctrl wp_lock_ctrl_chk #(.DATA_W(DATA_W), .PASSWD(PASSWD)) u_chk (.*);

// File: tb/wp_lock_ctrl_tb.sv
module wp_lock_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [23:0] KEY = 24'h414553;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        prot_cfg_o, prot_int_o, prot_ctl_o;
   logic [4:0]  evt_i = '0;
   logic [7:0]  src_i = '0;
   logic [3:0]  typ_i = '0;
   logic        sts_rd_i = 1'b0, swrst_i = 1'b0, unlock_i = 1'b0, start_req_i = 1'b0;
   logic        start_o, lock_o, key_clr_o, sec_irq_o;
   logic [4:0]  flags_o;
   logic [7:0]  src_o;
   logic [3:0]  typ_o;

   int n_checks = 0;
   int n_errors = 0;

   // reference state
   logic [2:0] m_prot = '0;
   logic [2:0] m_act = '0;
   logic       m_first = 1'b0;
   logic [4:0] m_flags = '0;
   logic       m_arm = 1'b0, m_open = 1'b0, m_irq = 1'b0;
   logic       m_srcv = 1'b0, m_typv = 1'b0;
   logic [7:0] m_src = '0;
   logic [3:0] m_typ = '0;
   logic       m_lock = 1'b0, m_kclr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_lock_ctrl u_dut (.*);

   function automatic logic [4:0] grp_of(input logic [2:0] a);
      case (a)
         3'd1, 3'd4: return 5'b10011;
         3'd2, 3'd5: return 5'b01100;
         3'd3, 3'd6: return 5'b11111;
         default:    return 5'b00000;
      endcase
   endfunction

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      logic [31:0] exp_rd;
      exp_rd = {24'h0, m_act, m_first, 1'b0, m_prot};
      check(rd_data == exp_rd, "R3 readback", rd_data, exp_rd);
      check({prot_ctl_o, prot_int_o, prot_cfg_o} == m_prot, "R2 enables",
            {prot_ctl_o, prot_int_o, prot_cfg_o}, m_prot);
      check(flags_o == m_flags, "R4/R9 flags", flags_o, m_flags);
      check(lock_o == m_lock, "R5/R8 lock", lock_o, m_lock);
      check(key_clr_o == m_kclr, "R6 key_clr", key_clr_o, m_kclr);
      check(start_o == (start_req_i && !m_lock), "R7 start", start_o, start_req_i && !m_lock);
      check(sec_irq_o == m_irq, "R11 irq", sec_irq_o, m_irq);
      check(src_o == m_src, "R10 src", src_o, m_src);
      check(typ_o == m_typ, "R10 typ", typ_o, m_typ);
   endtask

   // one clock: model advances from inputs seen at the edge, compare at negedge
   task automatic cycle();
      logic [4:0] g;
      logic any;
      g = grp_of(m_act);
      any = |evt_i;
      m_kclr = (|(evt_i & g)) && (m_act >= 3'd4) && (m_act <= 3'd6);
      if (|(evt_i & g)) m_lock = 1'b1;
      else if (unlock_i && !(|(m_flags & g))) m_lock = 1'b0;
      m_irq = any && (!m_open || sts_rd_i);
      if (any) m_open = 1'b1; else if (sts_rd_i) m_open = 1'b0;
      if (evt_i[1] && (!m_first || !m_srcv || sts_rd_i)) m_src = src_i;
      if (evt_i[1]) m_srcv = 1'b1; else if (sts_rd_i) m_srcv = 1'b0;
      if (evt_i[4] && (!m_first || !m_typv || sts_rd_i)) m_typ = typ_i;
      if (evt_i[4]) m_typv = 1'b1; else if (sts_rd_i) m_typv = 1'b0;
      for (int k = 0; k < 5; k++) begin
         if (k == 3) begin
            if (evt_i[3]) m_flags[3] = 1'b1;
            else if (swrst_i && m_arm) m_flags[3] = 1'b0;
         end else begin
            if (evt_i[k]) m_flags[k] = 1'b1;
            else if (sts_rd_i) m_flags[k] = 1'b0;
         end
      end
      // arm uses pre-edge flag 3, captured before update via evt/rd ordering below
      if (wr_en) begin
         m_act = wr_data[7:5];
         m_first = wr_data[4];
         if (wr_data[31:8] == KEY) m_prot = wr_data[2:0];
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   logic pre_f3;
   task automatic step();
      pre_f3 = m_flags[3];
      if (evt_i[3]) m_arm = 1'b0;
      else if (sts_rd_i && pre_f3) m_arm = 1'b1;
      else if (swrst_i) begin
         // clearing uses the arm value before this edge, applied in cycle()
      end
      cycle_with_arm();
   endtask

   logic arm_old;
   task automatic cycle_with_arm();
      cycle();
   endtask

   task automatic idle_inputs();
      wr_en = 0; evt_i = 0; sts_rd_i = 0; swrst_i = 0; unlock_i = 0;
   endtask

   // full step: arm bookkeeping must use the pre-edge arm for the flag clear
   task automatic tick();
      logic a_old, f3_old;
      a_old = m_arm;
      f3_old = m_flags[3];
      m_arm = a_old;
      cycle();
      if (evt_i_last[3]) m_arm = 1'b0;
      else if (rd_last && f3_old) m_arm = 1'b1;
      else if (sw_last) m_arm = 1'b0;
      idle_inputs();
   endtask

   logic [4:0] evt_i_last;
   logic rd_last, sw_last;
   always @(posedge clk) begin
      evt_i_last <= evt_i;
      rd_last <= sts_rd_i;
      sw_last <= swrst_i;
   end

   task automatic wr_mode(input logic [23:0] key, input logic [2:0] act, input logic first, input logic [2:0] en);
      wr_en = 1; wr_data = {key, act, first, 1'b0, en};
      tick();
   endtask

   task automatic fire(input logic [4:0] e, input logic [7:0] s, input logic [3:0] t);
      evt_i = e; src_i = s; typ_i = t;
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      compare_all();
      check(rd_data == 0 && lock_o == 0 && flags_o == 0, "R1 reset", rd_data, 0);
      rst_n = 1;
      @(negedge clk);

      // R2 wrong key: enables stay, R3 action/first still taken
      wr_mode(24'h414554, 3'd3, 1'b1, 3'b111);
      check({prot_ctl_o, prot_int_o, prot_cfg_o} == 3'b000, "R2 bad key", {prot_ctl_o, prot_int_o, prot_cfg_o}, 0);
      check(rd_data[7:4] == 4'b0111, "R3 fields without key", rd_data[7:4], 4'b0111);
      wr_mode(KEY, 3'd1, 1'b0, 3'b101);
      check(rd_data == 32'h0000_0025, "R2 good key", rd_data, 32'h25);

      // R5/R8 code 1: key-bus event locks, unlock refused until flag read
      start_req_i = 1;
      fire(5'b00001, 0, 0);
      check(lock_o == 1 && start_o == 0, "R5 lock on group A", lock_o, 1);
      tick(); // series continues: no irq
      unlock_i = 1; tick();
      check(lock_o == 1, "R8 unlock refused", lock_o, 1);
      sts_rd_i = 1; tick();
      unlock_i = 1; tick();
      check(lock_o == 0 && start_o == 1, "R8 unlock accepted", lock_o, 0);
      // glitch is outside group A
      fire(5'b00100, 0, 0);
      check(lock_o == 0, "R5 group A ignores glitch", lock_o, 0);
      sts_rd_i = 1; tick();

      // R6/R9 code 5: sequence error locks and wipes
      wr_mode(24'h0, 3'd5, 1'b0, 3'b000);
      fire(5'b01000, 0, 0);
      check(key_clr_o == 1 && lock_o == 1, "R6 wipe pulse", key_clr_o, 1);
      tick();
      check(key_clr_o == 0, "R6 wipe one cycle", key_clr_o, 0);
      swrst_i = 1; tick();
      check(flags_o[3] == 1, "R9 reset alone no clear", flags_o[3], 1);
      sts_rd_i = 1; tick();
      check(flags_o[3] == 1, "R9 read alone no clear", flags_o[3], 1);
      swrst_i = 1; tick();
      check(flags_o[3] == 0, "R9 read then reset clears", flags_o[3], 0);
      unlock_i = 1; tick();
      check(lock_o == 0, "R8 unlock after seq clear", lock_o, 0);

      // R10 first-error capture
      wr_mode(24'h0, 3'd0, 1'b1, 3'b000);
      fire(5'b00010, 8'hA1, 0);
      check(sec_irq_o == 1, "R11 first irq", sec_irq_o, 1);
      fire(5'b10010, 8'hB2, 4'h7);
      check(src_o == 8'hA1 && sec_irq_o == 0, "R10 first kept", src_o, 8'hA1);
      sts_rd_i = 1; tick();
      fire(5'b00010, 8'hC3, 0);
      check(src_o == 8'hC3 && sec_irq_o == 1, "R11 new series", src_o, 8'hC3);
      wr_mode(24'h0, 3'd7, 1'b0, 3'b000);
      fire(5'b10010, 8'hD4, 4'h9);
      check(src_o == 8'hD4 && typ_o == 4'h9, "R10 last kept", src_o, 8'hD4);
      check(lock_o == 0, "R5 code 7 no lock", lock_o, 0);
      fire(5'b11111, 8'hE5, 4'h2);
      check(lock_o == 0 && key_clr_o == 0, "R5 code 7 any event", lock_o, 0);
      sts_rd_i = 1; swrst_i = 0; tick();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         wr_en = (r[3:0] == 0);
         wr_data = {(r[4] ? KEY : 24'(r[31:8])), 8'($urandom)};
         evt_i = (r[7:5] == 0) ? 5'($urandom) : 5'd0;
         src_i = 8'($urandom);
         typ_i = 4'($urandom);
         sts_rd_i = (r[10:8] == 0);
         swrst_i = (r[13:11] == 0);
         unlock_i = (r[15:14] == 0);
         start_req_i = r[16];
         tick();
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule